// File: doc/BRIEF.md
# Predictor-Gated Sub-Block Content-Addressable Memory

This block is a binary content-addressable memory whose entries are grouped into equally sized sub-blocks. Each sub-block can be switched on for a search independently. A small predictor decides which sub-blocks to switch on. It reads only the low bits of the search tag, called the slice, and checks them against a bitmap learned from earlier writes. Only the enabled sub-blocks compare the full tag; the others do no comparison work. This cuts comparison activity in tables where most slices map to few sub-blocks.

A write stores a full tag at an entry address and marks, in the predictor, that the written sub-block now holds an entry with that slice. A clear command empties both the stored entries and the predictor bitmap. A search returns one cycle later. The result gives a response strobe, a hit flag, the matching address and the sub-block enable vector that was used.

Top module: `gated_cam`

## Requirements
- R1: After reset, and in the cycle after `clear_all`, no entry is valid and the predictor bitmap is empty. Every later search then returns `hit`=0 and `blk_en`=0 until a new write. A clear takes priority over a write in the same cycle.
- R2: A search for a tag stored at address A returns `hit`=1 and `hit_addr`=A, provided no entry at a lower address holds the same tag. The address is {sub-block index, entry index}, with the sub-block index in the upper `$clog2(NUM_BLK)` bits.
- R3: `blk_en` bit b is set when sub-block b has received at least one write since the last clear whose tag has the same low `SLICE_W` bits as the search tag. No other bit of `blk_en` is set.
- R4: When no bitmap bit is set for the search slice, the response is a miss with `blk_en`=0.
- R5: When several enabled entries match, `hit_addr` is the lowest matching address.
- R6: Rewriting an address replaces its tag, so the old tag no longer hits there. The predictor bit set by the old write stays set, so the stale bit can enable a sub-block with no match, and the result is a miss.
- R7: `rsp_valid`, `hit`, `hit_addr` and `blk_en` are registered. They reflect the search request sampled at the previous rising edge. With no request, `rsp_valid`=0, `hit`=0 and `blk_en`=0.
- R8: Matching is exact on all `TAG_W` bits. A tag that differs from a stored tag only above the slice bits misses, while its `blk_en` still shows the predicted sub-blocks.
- R9: A search issued in the same cycle as a write sees the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear_all | input | 1 | Invalidate all entries and empty the predictor |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | $clog2(NUM_BLK)+$clog2(BLK_DEPTH) | Entry address, sub-block index in upper bits |
| wr_tag | input | TAG_W | Tag to store |
| srch_en | input | 1 | Search request |
| srch_tag | input | TAG_W | Search key |
| rsp_valid | output | 1 | Search response strobe |
| hit | output | 1 | A matching entry was found |
| hit_addr | output | $clog2(NUM_BLK)+$clog2(BLK_DEPTH) | Lowest matching address |
| blk_en | output | NUM_BLK | Sub-blocks enabled for the search |

## Verification
On every cycle, the assertions check the following:
- the response strobe tracks the request;
- a hit always points into an enabled sub-block;
- an empty prediction never produces a hit;
- a clear leaves the bitmap empty;
- a write sets its predictor bit and lands its tag in the addressed entry.

Other properties need a reference model of the table contents, so only the bench's scenarios can show them. These are exact enable vectors, lowest-address selection among duplicates, stale predictor bits after overwrites, exact-match rejection of near tags, and read-before-write ordering.

// File: rtl/cam_pkg.sv
package cam_pkg;

    localparam int unsigned DEF_BLOCKS = 8;
    localparam int unsigned DEF_DEPTH  = 16;
    localparam int unsigned DEF_TAG_W  = 32;
    localparam int unsigned DEF_SLICE  = 6;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_CLEAR = 2'd2
    } tbl_op_e;

    function automatic tbl_op_e decode_op(input logic clr, input logic wr);
        if (clr)     return OP_CLEAR;
        else if (wr) return OP_WRITE;
        else         return OP_IDLE;
    endfunction

endpackage

// File: rtl/slice_predictor.sv
module slice_predictor
    import cam_pkg::*;
#(
    parameter int unsigned SLICE_W = DEF_SLICE,
    parameter int unsigned NUM_BLK = DEF_BLOCKS,
    localparam int unsigned ROWS   = 1 << SLICE_W,
    localparam int unsigned BLK_W  = $clog2(NUM_BLK)
) (
    input  logic               clk,
    input  logic               rst,
    input  tbl_op_e            op,
    input  logic [SLICE_W-1:0] wr_slice,
    input  logic [BLK_W-1:0]   wr_blk,
    input  logic [SLICE_W-1:0] rd_slice,
    output logic [NUM_BLK-1:0] rd_mask
);

    logic [NUM_BLK-1:0] bm_q [ROWS];

    always_ff @(posedge clk) begin
        if (rst || op == OP_CLEAR) begin
            for (int r = 0; r < ROWS; r++) bm_q[r] <= '0;
        end else if (op == OP_WRITE) begin
            bm_q[wr_slice][wr_blk] <= 1'b1;
        end
    end

    assign rd_mask = bm_q[rd_slice];

    // R1: a clear leaves every row empty
    a_r1_clear_empties: assert property (@(posedge clk) disable iff (rst)
        op == OP_CLEAR |=> rd_mask == '0);

    // R3: a write marks its sub-block for its slice
    a_r3_write_marks: assert property (@(posedge clk) disable iff (rst)
        ($past(op) == OP_WRITE && rd_slice == $past(wr_slice)) |-> rd_mask[$past(wr_blk)]);

endmodule

// File: rtl/cam_subblock.sv
module cam_subblock
    import cam_pkg::*;
#(
    parameter int unsigned TAG_W = DEF_TAG_W,
    parameter int unsigned DEPTH = DEF_DEPTH,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  tbl_op_e          op,
    input  logic             wr_sel,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             en,
    input  logic [TAG_W-1:0] key,
    output logic             match_any,
    output logic [IDX_W-1:0] match_idx
);

    logic [TAG_W-1:0] tag_q [DEPTH];
    logic [DEPTH-1:0] vld_q;
    logic [DEPTH-1:0] line_hit;

    always_ff @(posedge clk) begin
        if (rst || op == OP_CLEAR) begin
            vld_q <= '0;
        end else if (op == OP_WRITE && wr_sel) begin
            vld_q[wr_idx] <= 1'b1;
            tag_q[wr_idx] <= wr_tag;
        end
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            line_hit[i] = en && vld_q[i] && (tag_q[i] == key);
        end
    end

    always_comb begin
        match_any = |line_hit;
        match_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (line_hit[i]) match_idx = IDX_W'(i);
        end
    end

    // R2: a write lands its tag in the addressed entry
    a_r2_entry_stored: assert property (@(posedge clk) disable iff (rst)
        (op == OP_WRITE && wr_sel) |=> (vld_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag)));

endmodule

// File: rtl/gated_cam.sv
module gated_cam
    import cam_pkg::*;
#(
    parameter int unsigned NUM_BLK   = DEF_BLOCKS,
    parameter int unsigned BLK_DEPTH = DEF_DEPTH,
    parameter int unsigned TAG_W     = DEF_TAG_W,
    parameter int unsigned SLICE_W   = DEF_SLICE,
    localparam int unsigned BLK_W    = $clog2(NUM_BLK),
    localparam int unsigned IDX_W    = $clog2(BLK_DEPTH),
    localparam int unsigned ADDR_W   = BLK_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_all,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic              srch_en,
    input  logic [TAG_W-1:0]  srch_tag,
    output logic              rsp_valid,
    output logic              hit,
    output logic [ADDR_W-1:0] hit_addr,
    output logic [NUM_BLK-1:0] blk_en
);

    tbl_op_e            op;
    logic [NUM_BLK-1:0] pred_mask;
    logic [NUM_BLK-1:0] en_c;
    logic [NUM_BLK-1:0] sub_any;
    logic [IDX_W-1:0]   sub_idx [NUM_BLK];
    logic               hit_c;
    logic [ADDR_W-1:0]  addr_c;

    assign op = decode_op(clear_all, wr_en);

    slice_predictor #(.SLICE_W(SLICE_W), .NUM_BLK(NUM_BLK)) pred_i (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .wr_slice (wr_tag[SLICE_W-1:0]),
        .wr_blk   (wr_addr[ADDR_W-1:IDX_W]),
        .rd_slice (srch_tag[SLICE_W-1:0]),
        .rd_mask  (pred_mask)
    );

    assign en_c = srch_en ? pred_mask : '0;

    for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
        cam_subblock #(.TAG_W(TAG_W), .DEPTH(BLK_DEPTH)) sub_i (
            .clk       (clk),
            .rst       (rst),
            .op        (op),
            .wr_sel    (wr_addr[ADDR_W-1:IDX_W] == BLK_W'(b)),
            .wr_idx    (wr_addr[IDX_W-1:0]),
            .wr_tag    (wr_tag),
            .en        (en_c[b]),
            .key       (srch_tag),
            .match_any (sub_any[b]),
            .match_idx (sub_idx[b])
        );
    end

    always_comb begin
        hit_c  = 1'b0;
        addr_c = '0;
        for (int b = NUM_BLK - 1; b >= 0; b--) begin
            if (sub_any[b]) begin
                hit_c  = 1'b1;
                addr_c = {BLK_W'(b), sub_idx[b]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            hit       <= 1'b0;
            hit_addr  <= '0;
            blk_en    <= '0;
        end else begin
            rsp_valid <= srch_en;
            hit       <= hit_c;
            hit_addr  <= addr_c;
            blk_en    <= en_c;
        end
    end

    // R7: response follows request by one cycle
    a_r7_rsp_follows: assert property (@(posedge clk) disable iff (rst)
        srch_en |=> rsp_valid);
    a_r7_rsp_idle: assert property (@(posedge clk) disable iff (rst)
        !srch_en |=> (!rsp_valid && !hit && blk_en == '0));

    // R4: empty prediction cannot hit
    a_r4_empty_pred_miss: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && blk_en == '0) |-> !hit);

    // R3: a hit lies inside an enabled sub-block
    a_r3_hit_enabled: assert property (@(posedge clk) disable iff (rst)
        hit |-> blk_en[hit_addr[ADDR_W-1:IDX_W]]);

endmodule

// File: tb/gated_cam_tb_top.sv
module gated_cam_tb_top;

    localparam int NB = 8;
    localparam int DP = 16;
    localparam int TW = 32;
    localparam int SW = 6;
    localparam int N  = NB * DP;
    localparam int AW = 7;

    logic          clk = 1'b0;
    logic          rst;
    logic          clear_all;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [TW-1:0] wr_tag;
    logic          srch_en;
    logic [TW-1:0] srch_tag;
    logic          rsp_valid;
    logic          hit;
    logic [AW-1:0] hit_addr;
    logic [NB-1:0] blk_en;

    int n_chk  = 0;
    int n_fail = 0;

    logic [TW-1:0] m_tag [N];
    logic          m_vld [N];
    logic [NB-1:0] m_bm  [1 << SW];

    always #10 clk = ~clk;

    gated_cam dut_i (
        .clk(clk), .rst(rst), .clear_all(clear_all),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_tag(wr_tag),
        .srch_en(srch_en), .srch_tag(srch_tag),
        .rsp_valid(rsp_valid), .hit(hit), .hit_addr(hit_addr), .blk_en(blk_en)
    );

    function automatic logic [TW-1:0] tag_of(input int a);
        logic [25:0] up;
        logic [5:0]  sl;
        up = 26'(a * 1103 + 77);
        sl = 6'((a * 5) % 64);
        return {up, sl};
    endfunction

    function automatic logic [AW+NB+1:0] model(input logic [TW-1:0] t);
        logic [NB-1:0] msk;
        logic          h;
        logic [AW-1:0] ad;
        msk = m_bm[t[SW-1:0]];
        h   = 1'b0;
        ad  = '0;
        for (int a = N - 1; a >= 0; a--) begin
            if (msk[a / DP] && m_vld[a] && m_tag[a] == t) begin
                h  = 1'b1;
                ad = AW'(a);
            end
        end
        return {1'b1, h, ad, msk};
    endfunction

    task automatic check(input string req, input logic [AW+NB+1:0] act, input logic [AW+NB+1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {valid,hit,addr,blk_en} actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int a = 0; a < N; a++) m_vld[a] = 1'b0;
        for (int s = 0; s < (1 << SW); s++) m_bm[s] = '0;
    endtask

    task automatic model_write(input int a, input logic [TW-1:0] t);
        m_vld[a] = 1'b1;
        m_tag[a] = t;
        m_bm[t[SW-1:0]][a / DP] = 1'b1;
    endtask

    task automatic do_write(input int a, input logic [TW-1:0] t);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_tag = t;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, t);
    endtask

    task automatic do_clear();
        @(negedge clk);
        clear_all = 1'b1;
        @(negedge clk);
        clear_all = 1'b0;
        model_clear();
    endtask

    task automatic do_search(input string req, input logic [TW-1:0] t);
        logic [AW+NB+1:0] exp;
        @(negedge clk);
        srch_en = 1'b1; srch_tag = t;
        exp = model(t);
        @(negedge clk);
        srch_en = 1'b0;
        check(req, {rsp_valid, hit, hit_addr, blk_en}, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [AW+NB+1:0] exp;
        rst = 1'b1; clear_all = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_tag = '0;
        srch_en = 1'b0; srch_tag = '0;
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset state", {rsp_valid, hit, hit_addr, blk_en}, '0);
        for (int a = 0; a < N; a += 9) do_search("R1 R4 empty after reset", tag_of(a));

        // fill the whole table; each slice lands in two sub-blocks
        for (int a = 0; a < N; a++) do_write(a, tag_of(a));
        for (int a = 0; a < N; a++) do_search("R2 R3 stored tag hit", tag_of(a));
        for (int a = 0; a < N; a++) do_search("R8 near tag misses", tag_of(a) ^ (32'd1 << (SW + a % 26)));

        // idle cycle: no response
        @(negedge clk);
        @(negedge clk);
        check("R7 idle response", {rsp_valid, hit, hit_addr, blk_en}, '0);

        // duplicate at a lower address; old tag of that address gone
        do_write(3, tag_of(100));
        do_search("R5 lowest duplicate", tag_of(100));
        do_search("R6 overwritten tag misses", tag_of(3));
        do_write(120, tag_of(40));
        do_search("R5 lowest across blocks", tag_of(40));

        // write and search together on the same tag
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(10); wr_tag = 32'hDEAD_BEE5;
        srch_en = 1'b1; srch_tag = 32'hDEAD_BEE5;
        exp = model(32'hDEAD_BEE5);
        @(negedge clk);
        wr_en = 1'b0; srch_en = 1'b0;
        check("R9 search sees pre-write table", {rsp_valid, hit, hit_addr, blk_en}, exp);
        model_write(10, 32'hDEAD_BEE5);
        do_search("R9 write visible after", 32'hDEAD_BEE5);

        // clear then sparse contents
        do_clear();
        for (int a = 0; a < N; a += 7) do_search("R1 empty after clear", tag_of(a));
        do_write(37, 32'h0000_1207);
        do_write(90, 32'h0000_3307);
        do_search("R4 unpredicted slice", 32'h0000_1208);
        do_search("R3 R2 sparse hit", 32'h0000_3307);
        do_search("R8 sparse near miss", 32'h8000_1207);

        // clear wins over write in the same cycle
        @(negedge clk);
        clear_all = 1'b1; wr_en = 1'b1; wr_addr = AW'(5); wr_tag = 32'h0000_0011;
        @(negedge clk);
        clear_all = 1'b0; wr_en = 1'b0;
        model_clear();
        do_search("R1 clear beats write", 32'h0000_0011);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule